// File: doc/BRIEF.md
# Multilevel Stacked-Carrier Modulator

This block turns three per-phase duty cycles into switching states for an n-level voltage-source converter. Each signed fixed-point duty cycle (1.0 equals `2**FRAC`) is scaled by n−1. It is then compared against n−1 triangle carriers of unit height that sit one above the other. The number of carriers that the scaled duty reaches becomes the phase state, a value from 0 to n−1. The ideal line-to-ground level of the phase is that state times the DC-link voltage divided by n−1.

All carriers come from one shared triangle counter. The counter moves by a programmable step each clock, so the switching period is `2**(FRAC+1)/step` clocks when the step divides 1.0. A one-cycle strobe marks every reversal of the carrier. The three phase states are also packed into one base-n word. Each state is decoded into the gate pattern of a diode-clamped leg with 2(n−1) switches.

Top module: `mlcpwm`

## Requirements
- R1: While reset is applied, and until the third rising clock edge after it is released, all phase states, the packed word and the strobe are 0, and every gate pattern equals the pattern of state 0.
- R2: At every clock edge, each phase state takes the count of carriers k (k = 1..n−1) for which duty·(n−1) ≥ carrier value + (k−1)·1.0. The carrier value is the one held just before that edge.
- R3: A duty cycle of zero or below gives state 0 at the next edge, whatever the carrier value.
- R4: A duty cycle of 1.0 or above gives state n−1 at the next edge.
- R5: After reset the shared carrier starts at 0 and rises. On each edge it moves by `step`. Moving up, it clamps at 1.0 and then falls. Moving down, it clamps at 0 and then rises.
- R6: `carrier_turn` is high for exactly the cycle in which the carrier holds a newly reached 1.0 or 0. When `step` is below 1.0, the strobe is never high in two consecutive cycles.
- R7: A `step` of 0 freezes the carrier and its direction, and the strobe stays low.
- R8: `sw_state` equals n²·state_a + n·state_b + state_c in the same cycle as the states.
- R9: Each gate vector has bit i for switch i, counted from the lowest switch. Exactly n−1 adjacent bits are 1, starting at bit index equal to the phase state, so state 0 turns on bits 0..n−2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| duty_a | input | DUTY_W | Signed duty cycle of phase a, 1.0 = 2**FRAC |
| duty_b | input | DUTY_W | Signed duty cycle of phase b |
| duty_c | input | DUTY_W | Signed duty cycle of phase c |
| step | input | FRAC+1 | Carrier increment per clock; 0 freezes the carrier |
| state_a | output | clog2(N) | Switching state of phase a |
| state_b | output | clog2(N) | Switching state of phase b |
| state_c | output | clog2(N) | Switching state of phase c |
| sw_state | output | clog2(N**3) | Packed base-N switching state |
| carrier_turn | output | 1 | One-cycle strobe at each carrier peak or valley |
| gate_a | output | 2(N−1) | Diode-clamped leg gate enables, phase a |
| gate_b | output | 2(N−1) | Diode-clamped leg gate enables, phase b |
| gate_c | output | 2(N−1) | Diode-clamped leg gate enables, phase c |

## Verification
Phase states and the strobe change one clock edge after the duty and step they depend on. The comparison uses the carrier value held before that edge. The packed word and the gate patterns follow the states in the same cycle, with no further edge. Functional updates begin on the third edge after reset is released. The bench carries its own model of the carrier. Before each edge it computes every expected result from the duty, the step and the modelled carrier value of that cycle. It then compares just after the edge, and it changes inputs only after that comparison.

// File: rtl/mlcpwm_pkg.sv
package mlcpwm_pkg;
  typedef enum logic {CAR_FALL = 1'b0, CAR_RISE = 1'b1} car_dir_e;
endpackage

// File: rtl/mlcpwm_carrier.sv
module mlcpwm_carrier
  import mlcpwm_pkg::*;
#(
  parameter int FRAC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FRAC:0]   step,
  output logic [FRAC:0]   tri_o,
  output logic            turn_o
);
  localparam logic [FRAC+1:0] ONE_W = {2'b01, {FRAC{1'b0}}};

  logic [FRAC:0]   tri_q, tri_d;
  car_dir_e        dir_q, dir_d;
  logic            turn_q, turn_d;
  logic            adv_en;
  logic [FRAC+1:0] sum_w;

  assign adv_en = (step != '0);
  assign sum_w  = {1'b0, tri_q} + {1'b0, step};

  always_comb begin
    tri_d  = tri_q;
    dir_d  = dir_q;
    turn_d = 1'b0;
    if (dir_q == CAR_RISE) begin
      if (sum_w >= ONE_W) begin
        tri_d  = ONE_W[FRAC:0];
        dir_d  = CAR_FALL;
        turn_d = 1'b1;
      end else begin
        tri_d = sum_w[FRAC:0];
      end
    end else begin
      if (tri_q <= step) begin
        tri_d  = '0;
        dir_d  = CAR_RISE;
        turn_d = 1'b1;
      end else begin
        tri_d = tri_q - step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_q  <= '0;
      dir_q  <= CAR_RISE;
      turn_q <= 1'b0;
    end else begin
      if (adv_en) begin
        tri_q <= tri_d;
        dir_q <= dir_d;
      end
      turn_q <= adv_en & turn_d;
    end
  end

  assign tri_o  = tri_q;
  assign turn_o = turn_q;
endmodule

// File: rtl/mlcpwm_level.sv
module mlcpwm_level #(
  parameter int N      = 4,
  parameter int DUTY_W = 12,
  parameter int FRAC   = 10,
  parameter int LW     = (N > 2) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DUTY_W-1:0] duty,
  input  logic [FRAC:0]            tri_i,
  output logic [LW-1:0]            state_o
);
  localparam int SC_W = DUTY_W + 4;
  localparam logic signed [SC_W-1:0] MULT = SC_W'(N - 1);

  logic signed [SC_W-1:0] duty_x, scaled;
  logic                   pos;
  logic [N-2:0]           hit;
  logic [LW-1:0]          cnt_d, state_q;

  assign duty_x = SC_W'(duty);
  assign scaled = duty_x * MULT;
  assign pos    = (scaled > 0);

  for (genvar k = 0; k < N - 1; k++) begin : g_car
    localparam logic signed [SC_W-1:0] OFS = SC_W'(k * (2 ** FRAC));
    logic signed [SC_W-1:0] car_v;
    assign car_v  = $signed({{(SC_W-FRAC-1){1'b0}}, tri_i}) + OFS;
    assign hit[k] = pos && (scaled >= car_v);
  end

  always_comb begin
    cnt_d = '0;
    for (int i = 0; i < N - 1; i++) begin
      cnt_d = cnt_d + LW'(hit[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= cnt_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/mlcpwm_legdec.sv
module mlcpwm_legdec #(
  parameter int N  = 4,
  parameter int LW = (N > 2) ? $clog2(N) : 1,
  parameter int G  = 2 * (N - 1)
) (
  input  logic [LW-1:0] state_i,
  output logic [G-1:0]  gate_o
);
  always_comb begin
    for (int i = 0; i < G; i++) begin
      gate_o[i] = (i >= int'(state_i)) && (i < int'(state_i) + N - 1);
    end
  end
endmodule

// File: rtl/mlcpwm.sv
module mlcpwm #(
  parameter int N      = 4,
  parameter int DUTY_W = 12,
  parameter int FRAC   = 10,
  parameter int LW     = (N > 2) ? $clog2(N) : 1,
  parameter int SW_W   = $clog2(N * N * N),
  parameter int G      = 2 * (N - 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DUTY_W-1:0] duty_a,
  input  logic signed [DUTY_W-1:0] duty_b,
  input  logic signed [DUTY_W-1:0] duty_c,
  input  logic [FRAC:0]            step,
  output logic [LW-1:0]            state_a,
  output logic [LW-1:0]            state_b,
  output logic [LW-1:0]            state_c,
  output logic [SW_W-1:0]          sw_state,
  output logic                     carrier_turn,
  output logic [G-1:0]             gate_a,
  output logic [G-1:0]             gate_b,
  output logic [G-1:0]             gate_c
);
  logic [1:0]              rs_q;
  logic                    rst_sync_n;
  logic [FRAC:0]           tri_w;
  logic signed [DUTY_W-1:0] duty_v [3];
  logic [LW-1:0]           st_v   [3];
  logic [G-1:0]            gt_v   [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  mlcpwm_carrier #(.FRAC(FRAC)) u_carrier (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .step   (step),
    .tri_o  (tri_w),
    .turn_o (carrier_turn)
  );

  assign duty_v[0] = duty_a;
  assign duty_v[1] = duty_b;
  assign duty_v[2] = duty_c;

  for (genvar p = 0; p < 3; p++) begin : g_ph
    mlcpwm_level #(.N(N), .DUTY_W(DUTY_W), .FRAC(FRAC), .LW(LW)) u_level (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .duty    (duty_v[p]),
      .tri_i   (tri_w),
      .state_o (st_v[p])
    );
    mlcpwm_legdec #(.N(N), .LW(LW), .G(G)) u_dec (
      .state_i (st_v[p]),
      .gate_o  (gt_v[p])
    );
  end

  assign state_a = st_v[0];
  assign state_b = st_v[1];
  assign state_c = st_v[2];
  assign gate_a  = gt_v[0];
  assign gate_b  = gt_v[1];
  assign gate_c  = gt_v[2];

  assign sw_state = SW_W'(st_v[0]) * SW_W'(N * N)
                  + SW_W'(st_v[1]) * SW_W'(N)
                  + SW_W'(st_v[2]);
endmodule

// File: rtl/mlcpwm_chk.sv
module mlcpwm_chk #(
  parameter int N      = 4,
  parameter int DUTY_W = 12,
  parameter int FRAC   = 10,
  parameter int LW     = (N > 2) ? $clog2(N) : 1,
  parameter int SW_W   = $clog2(N * N * N),
  parameter int G      = 2 * (N - 1)
) (
  input logic                     clk,
  input logic                     rst_i,
  input logic signed [DUTY_W-1:0] duty_a,
  input logic [FRAC:0]            step,
  input logic [LW-1:0]            state_a,
  input logic [LW-1:0]            state_c,
  input logic [SW_W-1:0]          sw_state,
  input logic                     carrier_turn,
  input logic [G-1:0]             gate_a
);
  localparam logic signed [DUTY_W-1:0] ONE_S = DUTY_W'(2 ** FRAC);
  localparam logic [FRAC:0]            ONE_U = (FRAC+1)'(2 ** FRAC);

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_i)
    int'(state_a) <= N - 1); // R2
  AST_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_i)
    (duty_a <= 0) |=> (state_a == '0)); // R3
  AST_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_i)
    (duty_a >= ONE_S) |=> (int'(state_a) == N - 1)); // R4
  AST_TURN_SINGLE: assert property (@(posedge clk) disable iff (!rst_i)
    (carrier_turn && (step < ONE_U)) |=> !carrier_turn); // R6
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    (step == '0) |=> !carrier_turn); // R7
  AST_SW_LOW_DIGIT: assert property (@(posedge clk) disable iff (!rst_i)
    (int'(sw_state) % N) == int'(state_c)); // R8
  AST_GATE_COUNT: assert property (@(posedge clk) disable iff (!rst_i)
    $countones(gate_a) == N - 1); // R9
  AST_GATE_BASE: assert property (@(posedge clk) disable iff (!rst_i)
    (state_a == '0) |-> (gate_a[N-2:0] == '1)); // R9
endmodule

bind mlcpwm mlcpwm_chk #(
  .N(N), .DUTY_W(DUTY_W), .FRAC(FRAC), .LW(LW), .SW_W(SW_W), .G(G)
) u_chk (
  .clk          (clk),
  .rst_i        (rst_sync_n),
  .duty_a       (duty_a),
  .step         (step),
  .state_a      (state_a),
  .state_c      (state_c),
  .sw_state     (sw_state),
  .carrier_turn (carrier_turn),
  .gate_a       (gate_a)
);

// File: tb/mlcpwm_bench.sv
`timescale 1ns/1ps
module mlcpwm_bench;
  localparam int N = 4, DUTY_W = 8, FRAC = 4, ONE = 16;
  localparam int LW = 2, SW_W = 6, G = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [DUTY_W-1:0] da = '0, db = '0, dc = '0;
  logic [FRAC:0] step = '0;
  logic [LW-1:0] state_a, state_b, state_c;
  logic [SW_W-1:0] sw_state;
  logic carrier_turn;
  logic [G-1:0] gate_a, gate_b, gate_c;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_tri = 0;
  bit m_up = 1'b1;

  always #2.5 clk = ~clk;

  mlcpwm #(.N(N), .DUTY_W(DUTY_W), .FRAC(FRAC)) u_mlcpwm (
    .clk(clk), .rst_n(rst_n), .duty_a(da), .duty_b(db), .duty_c(dc),
    .step(step), .state_a(state_a), .state_b(state_b), .state_c(state_c),
    .sw_state(sw_state), .carrier_turn(carrier_turn),
    .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_state(input int d, input int tri_v);
    int n = 0;
    if (d <= 0) return 0;
    for (int k = 1; k < N; k++)
      if (d * (N - 1) >= tri_v + (k - 1) * ONE) n++;
    return n;
  endfunction

  function automatic int exp_gate(input int s);
    int g = 0;
    for (int i = 0; i < G; i++)
      if (i >= s && i < s + N - 1) g |= (1 << i);
    return g;
  endfunction

  function automatic string dtag(input int d);
    if (d <= 0) return "R3";
    if (d >= ONE) return "R4";
    return "R2 R5";
  endfunction

  task automatic tick();
    int ea, eb, ec, nt, st;
    bit nu, et;
    ea = exp_state(int'(da), m_tri);
    eb = exp_state(int'(db), m_tri);
    ec = exp_state(int'(dc), m_tri);
    st = int'(step);
    nt = m_tri; nu = m_up; et = 1'b0;
    if (st != 0) begin
      if (m_up) begin
        if (m_tri + st >= ONE) begin nt = ONE; nu = 1'b0; et = 1'b1; end
        else nt = m_tri + st;
      end else begin
        if (m_tri <= st) begin nt = 0; nu = 1'b1; et = 1'b1; end
        else nt = m_tri - st;
      end
    end
    @(posedge clk); #1;
    chk({"state_a ", dtag(int'(da))}, int'(state_a), ea);
    chk({"state_b ", dtag(int'(db))}, int'(state_b), eb);
    chk({"state_c ", dtag(int'(dc))}, int'(state_c), ec);
    chk("R8 sw_state", int'(sw_state), ea * N * N + eb * N + ec);
    chk("R9 gate_a", int'(gate_a), exp_gate(ea));
    chk("R9 gate_c", int'(gate_c), exp_gate(ec));
    chk(st == 0 ? "R7 carrier_turn" : "R6 carrier_turn", int'(carrier_turn), int'(et));
    m_tri = nt; m_up = nu;
  endtask

  task automatic reset_checks();
    chk("R1 state_a", int'(state_a), 0);
    chk("R1 state_b", int'(state_b), 0);
    chk("R1 sw_state", int'(sw_state), 0);
    chk("R1 carrier_turn", int'(carrier_turn), 0);
    chk("R1 gate_b", int'(gate_b), exp_gate(0));
  endtask

  task automatic set_duty(input int d);
    da = DUTY_W'(d);
    db = DUTY_W'(17 - d);
    dc = DUTY_W'((d * 5) % 23 - 3);
  endtask

  initial begin
    step = 5'd1;
    da = 8'sd12; db = 8'sd20; dc = -8'sd3;
    #12;
    reset_checks();
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: two more edges held by the synchronizer
    for (int i = 0; i < 2; i++) begin
      @(posedge clk); #1;
      reset_checks();
    end
    // R2 R3 R4 R5: full duty sweep over whole carrier periods, step 1
    for (int d = -3; d <= 20; d++) begin
      set_duty(d);
      for (int c = 0; c < 34; c++) tick();
    end
    // R5 R6: other step sizes, including ones that do not divide 1.0
    step = 5'd3;
    for (int d = 0; d <= 18; d += 3) begin
      set_duty(d);
      for (int c = 0; c < 25; c++) tick();
    end
    // R7: frozen carrier
    step = 5'd0;
    set_duty(7);
    for (int c = 0; c < 12; c++) tick();
    // R6: step of a full unit reverses every cycle
    step = 5'd16;
    set_duty(9);
    for (int c = 0; c < 10; c++) tick();
    step = 5'd5;
    for (int d = -1; d <= 17; d += 6) begin
      set_duty(d);
      for (int c = 0; c < 20; c++) tick();
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule